// File: doc/BRIEF.md
# Page-Mode Multiplexed Bus Demultiplexer

This block sits on the slave side of a byte-wide microcontroller bus on which one group of pins is shared between part of the address and the data. It rebuilds a full 16-bit address, a one-cycle read request and a one-cycle write pulse with its data for an internal register or memory port. Read data from that port goes back onto the shared pins through an output enable.

A static mode input selects which address byte is multiplexed. In non-page mode the shared pins carry the low address byte before the data, and the dedicated pins carry the high byte. In page mode the shared pins carry the high byte before the data, and the dedicated pins carry the low byte. In page mode a cycle that stays inside the current page has no latch strobe. The block then reuses the high byte it latched earlier and takes the low byte live from the dedicated pins. Any change of that low byte during a read starts a fresh internal access.

All bus inputs are taken as already synchronous to `clk`. The latched byte follows the shared pins on every clock while the latch strobe is high, and it is frozen once the strobe drops.

Top module: `mux_bus_demux`

## Requirements
- R1: After reset, `mem_rd_o`, `mem_wr_o`, `ad_oe_o` and `mem_addr_o` are 0 and the latched byte is 0, so a page-mode read with no preceding latch strobe presents address {8'h00, dedicated byte}.
- R2: In non-page mode (`page_mode_i`=0) the address of an access is {dedicated pins, latched shared byte}.
- R3: In page mode (`page_mode_i`=1) the address of an access after a latch strobe is {latched shared byte, dedicated pins}.
- R4: In page mode, a cycle without a latch strobe reuses the high byte from the most recent strobe, with the low byte taken from the dedicated pins.
- R5: Once `ale_i` is low, changes on `ad_i` (data phase, idle values) do not alter the latched byte or the assembled address.
- R6: The clock edge that first sees `rd_n_i` or `psen_n_i` low produces `mem_rd_o`=1 for exactly one cycle, with `mem_addr_o` holding the assembled address in that same cycle.
- R7: `ad_oe_o` is 1 while a read strobe is low and `ale_i` is low, and 0 in the same cycle the strobe returns high. While it is 1, `ad_o` equals `mem_rd_data_i`.
- R8: The clock edge that sees `wr_n_i` return high produces `mem_wr_o`=1 for one cycle, with `mem_addr_o` set to the assembled address and `mem_wdata_o` set to the `ad_i` value sampled at that edge.
- R9: In page mode, a change of the dedicated pins while a read strobe stays low gives a new one-cycle `mem_rd_o` with the new address at the next edge. In non-page mode such a change gives no new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| page_mode_i | input | 1 | 1 = page mode, 0 = non-page mode (static) |
| ale_i | input | 1 | Address latch strobe, active high |
| rd_n_i | input | 1 | Data read strobe, active low |
| psen_n_i | input | 1 | Code read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| ad_i | input | 8 | Shared address/data pins, inbound |
| fix_i | input | 8 | Dedicated address pins |
| ad_o | output | 8 | Shared pins, outbound read data |
| ad_oe_o | output | 1 | Output enable for the shared pins |
| mem_addr_o | output | 16 | Assembled access address |
| mem_rd_o | output | 1 | One-cycle internal read request |
| mem_rd_data_i | input | 8 | Read data from the internal port |
| mem_wr_o | output | 1 | One-cycle internal write pulse |
| mem_wdata_o | output | 8 | Write data for the internal port |

## Verification
The bench builds the block with its default byte width of 8 and a 16-bit address, which is the only width the two-byte assembly needs. That setting lets a short table mix page misses, page hits and non-page cycles with both read strobes and writes, so the carried high byte is checked across hit cycles. Directed tests then cover the zero latch after reset, a low-byte change during a held read in each mode, and the release of the enable in the cycle the strobe drops.

// File: rtl/mbd_pkg.sv
// Package: shared widths and the bus-mode type for the bus demultiplexer.
// Assumes: one address is exactly two bytes of the bus width.
package mbd_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned ADDR_W = 2 * BYTE_W;

    typedef enum logic {
        MODE_FLAT = 1'b0,
        MODE_PAGE = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/mbd_addr_latch.sv
// Module: address byte latch and address assembly.
// Does: follows the shared pins while the latch strobe is high and keeps the
// byte once it falls. It forms the full address with the multiplexed byte
// placed low (flat mode) or high (page mode).
// Assumes: inputs synchronous to clk; mode static between accesses.
module mbd_addr_latch #(
    parameter int unsigned BW = 8,
    localparam int unsigned AW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_mode_i,
    input  logic          ale_i,
    input  logic [BW-1:0] ad_i,
    input  logic [BW-1:0] fix_i,
    output logic [AW-1:0] asm_addr_o
);
    logic [BW-1:0] held_q;
    logic [BW-1:0] mux_byte;

    // Capture the shared byte on every clock while the strobe is high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            held_q <= '0;
        else if (ale_i)
            held_q <= ad_i;
    end

    // Transparent view: live pins while strobe high, held byte otherwise.
    always_comb mux_byte = ale_i ? ad_i : held_q;

    // Place the multiplexed byte according to the selected mode.
    generate
        if (AW == 2 * BW) begin : g_two_byte
            always_comb begin
                if (page_mode_i == mbd_pkg::MODE_PAGE)
                    asm_addr_o = {mux_byte, fix_i};
                else
                    asm_addr_o = {fix_i, mux_byte};
            end
        end
    endgenerate

    // The held byte moves only after a clock that saw the strobe high (R5).
    p_hold_when_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ale_i) |-> $stable(held_q));
endmodule

// File: rtl/mbd_strobe_ctl.sv
// Module: strobe edge detection for the demultiplexer.
// Does: flags a read start on the leading edge of either read strobe, a
// page-mode restart when the dedicated pins move during a read, and a write
// at the trailing edge of the write strobe.
// Assumes: strobes synchronous to clk and glitch free.
module mbd_strobe_ctl #(
    parameter int unsigned BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_mode_i,
    input  logic          rd_n_i,
    input  logic          psen_n_i,
    input  logic          wr_n_i,
    input  logic [BW-1:0] fix_i,
    output logic          rd_active_o,
    output logic          rd_go_o,
    output logic          wr_go_o
);
    logic          rd_act_q;
    logic          wr_n_q;
    logic [BW-1:0] fix_q;
    logic          rd_lead;
    logic          rd_move;

    // Either active-low read strobe counts as a read.
    always_comb rd_active_o = !rd_n_i || !psen_n_i;

    // Previous strobe levels and dedicated pins for edge and change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            wr_n_q   <= 1'b1;
            fix_q    <= '0;
        end else begin
            rd_act_q <= rd_active_o;
            wr_n_q   <= wr_n_i;
            fix_q    <= fix_i;
        end
    end

    // Read start and page-mode restart conditions.
    always_comb begin
        rd_lead = rd_active_o && !rd_act_q;
        rd_move = page_mode_i && rd_active_o && rd_act_q && (fix_i != fix_q);
        rd_go_o = rd_lead || rd_move;
        wr_go_o = wr_n_i && !wr_n_q;
    end

    // A read request always comes with a live read strobe (R6).
    p_go_needs_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go_o |-> rd_active_o);
    // A write is flagged only on the low-to-high edge of the write strobe (R8).
    p_wr_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go_o |-> (wr_n_i && !$past(wr_n_i)));
endmodule

// File: rtl/mux_bus_demux.sv
// Module: top of the multiplexed-bus demultiplexer.
// Does: combines latch and strobe control, registers the access address,
// read request, write pulse and write data, and drives read data back on the
// shared pins under an output enable.
// Assumes: bus inputs synchronous to clk; a write edge wins over a read start
// in the same cycle.
module mux_bus_demux #(
    parameter int unsigned BW = mbd_pkg::BYTE_W,
    localparam int unsigned AW = 2 * BW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          page_mode_i,
    input  logic          ale_i,
    input  logic          rd_n_i,
    input  logic          psen_n_i,
    input  logic          wr_n_i,
    input  logic [BW-1:0] ad_i,
    input  logic [BW-1:0] fix_i,
    output logic [BW-1:0] ad_o,
    output logic          ad_oe_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          mem_rd_o,
    input  logic [BW-1:0] mem_rd_data_i,
    output logic          mem_wr_o,
    output logic [BW-1:0] mem_wdata_o
);
    logic [AW-1:0] asm_addr;
    logic          rd_active;
    logic          rd_go;
    logic          wr_go;

    mbd_addr_latch #(.BW(BW)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .page_mode_i (page_mode_i),
        .ale_i       (ale_i),
        .ad_i        (ad_i),
        .fix_i       (fix_i),
        .asm_addr_o  (asm_addr)
    );

    mbd_strobe_ctl #(.BW(BW)) u_strobe (
        .clk         (clk),
        .rst_n       (rst_n),
        .page_mode_i (page_mode_i),
        .rd_n_i      (rd_n_i),
        .psen_n_i    (psen_n_i),
        .wr_n_i      (wr_n_i),
        .fix_i       (fix_i),
        .rd_active_o (rd_active),
        .rd_go_o     (rd_go),
        .wr_go_o     (wr_go)
    );

    // Register the access: address on any start, data on a write edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr_o  <= '0;
            mem_rd_o    <= 1'b0;
            mem_wr_o    <= 1'b0;
            mem_wdata_o <= '0;
        end else begin
            mem_wr_o <= wr_go;
            mem_rd_o <= rd_go && !wr_go;
            if (wr_go || rd_go)
                mem_addr_o <= asm_addr;
            if (wr_go)
                mem_wdata_o <= ad_i;
        end
    end

    // Drive the shared pins only during the data phase of a read.
    always_comb begin
        ad_oe_o = rd_active && !ale_i;
        ad_o    = ad_oe_o ? mem_rd_data_i : '0;
    end

    // The write pulse lasts one cycle (R8).
    p_wr_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |=> !mem_wr_o);
    // The enable is never on without a read strobe (R7).
    p_oe_needs_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> (!rd_n_i || !psen_n_i));
    // Read request and write pulse never overlap (R6).
    p_rd_wr_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mem_rd_o, mem_wr_o}) <= 1);
    // A read request follows a cycle with a read strobe low (R6).
    p_rd_after_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_o |-> $past(!rd_n_i || !psen_n_i));
endmodule

// File: tb/mux_bus_demux_tb_top.sv
// Bench: table of bus cycles walked by one loop, then directed corner tests.
module mux_bus_demux_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    typedef struct packed {
        logic        pg;
        logic        use_ale;
        logic [1:0]  op;     // 0 read RD, 1 read PSEN, 2 write
        logic [7:0]  fix;
        logic [7:0]  shr;
        logic [7:0]  dat;
        logic [15:0] exp_addr;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        '{1'b0, 1'b1, 2'd0, 8'h12, 8'h34, 8'hA5, 16'h1234},
        '{1'b0, 1'b1, 2'd2, 8'h56, 8'h78, 8'h3C, 16'h5678},
        '{1'b1, 1'b1, 2'd0, 8'h9A, 8'hBC, 8'h11, 16'hBC9A},
        '{1'b1, 1'b0, 2'd0, 8'h01, 8'hFF, 8'h22, 16'hBC01},
        '{1'b1, 1'b0, 2'd2, 8'h02, 8'hFF, 8'h44, 16'hBC02},
        '{1'b1, 1'b1, 2'd2, 8'hFE, 8'h80, 8'h99, 16'h80FE},
        '{1'b1, 1'b0, 2'd1, 8'h7F, 8'h00, 8'h66, 16'h807F},
        '{1'b0, 1'b1, 2'd1, 8'h00, 8'hFF, 8'h5A, 16'h00FF}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        page_mode = 1'b0;
    logic        ale = 1'b0;
    logic        rd_n = 1'b1;
    logic        psen_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  ad_in = 8'h00;
    logic [7:0]  fix = 8'h00;
    logic [7:0]  rdata = 8'h00;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [15:0] maddr;
    logic        mrd;
    logic        mwr;
    logic [7:0]  mwdata;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mux_bus_demux dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .page_mode_i   (page_mode),
        .ale_i         (ale),
        .rd_n_i        (rd_n),
        .psen_n_i      (psen_n),
        .wr_n_i        (wr_n),
        .ad_i          (ad_in),
        .fix_i         (fix),
        .ad_o          (ad_out),
        .ad_oe_o       (ad_oe),
        .mem_addr_o    (maddr),
        .mem_rd_o      (mrd),
        .mem_rd_data_i (rdata),
        .mem_wr_o      (mwr),
        .mem_wdata_o   (mwdata)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One bus cycle: optional latch phase, then read or write data phase.
    task automatic bus_cycle(input vec_t v, input string req);
        @(negedge clk);
        page_mode = v.pg;
        fix = v.fix;
        ad_in = v.shr;
        ale = v.use_ale;
        @(negedge clk);
        ale = 1'b0;
        ad_in = 8'hEE;                       // R5: idle value after strobe falls
        if (v.op == 2'd2) begin
            ad_in = v.dat;
            wr_n = 1'b0;
            @(negedge clk);
            wr_n = 1'b1;
            @(negedge clk);
            check(mwr == 1'b1, req, "R8 write pulse", {15'd0, mwr}, 16'd1);
            check(maddr == v.exp_addr, req, "R8 write addr", maddr, v.exp_addr);
            check(mwdata == v.dat, req, "R8 write data", {8'd0, mwdata}, {8'd0, v.dat});
            @(negedge clk);
            check(mwr == 1'b0, req, "R8 pulse length", {15'd0, mwr}, 16'd0);
        end else begin
            rdata = v.dat;
            if (v.op == 2'd1) psen_n = 1'b0; else rd_n = 1'b0;
            @(negedge clk);
            check(mrd == 1'b1, req, "R6 read request", {15'd0, mrd}, 16'd1);
            check(maddr == v.exp_addr, req, "R6 read addr", maddr, v.exp_addr);
            check(ad_oe == 1'b1, req, "R7 enable on", {15'd0, ad_oe}, 16'd1);
            check(ad_out == v.dat, req, "R7 read data", {8'd0, ad_out}, {8'd0, v.dat});
            @(negedge clk);
            check(mrd == 1'b0, req, "R6 request length", {15'd0, mrd}, 16'd0);
            rd_n = 1'b1;
            psen_n = 1'b1;
            #1;
            check(ad_oe == 1'b0, req, "R7 enable release", {15'd0, ad_oe}, 16'd0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        vec_t hv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(mrd == 1'b0 && mwr == 1'b0, "R1", "pulses idle", {14'd0, mrd, mwr}, 16'd0);
        check(ad_oe == 1'b0, "R1", "enable idle", {15'd0, ad_oe}, 16'd0);
        check(maddr == 16'h0000, "R1", "address zero", maddr, 16'h0000);

        // R1/R4: page read with no strobe since reset uses a zero high byte
        hv = '{1'b1, 1'b0, 2'd0, 8'h3D, 8'h77, 8'hC3, 16'h003D};
        bus_cycle(hv, "R1");

        // Table walk: R2, R3, R4, R5, R6, R7, R8
        for (int i = 0; i < NVEC; i++) begin
            bus_cycle(TBL[i], TBL[i].pg ? (TBL[i].use_ale ? "R3" : "R4") : "R2");
        end

        // R9: page mode, low byte moves while RD held low
        hv = '{1'b1, 1'b1, 2'd0, 8'h10, 8'h4C, 8'h01, 16'h4C10};
        @(negedge clk);
        page_mode = 1'b1; fix = hv.fix; ad_in = hv.shr; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0; ad_in = 8'h00; rd_n = 1'b0;
        @(negedge clk);
        check(mrd == 1'b1 && maddr == 16'h4C10, "R9", "first page read", maddr, 16'h4C10);
        fix = 8'h11;
        @(negedge clk);
        check(mrd == 1'b1, "R9", "restart pulse", {15'd0, mrd}, 16'd1);
        check(maddr == 16'h4C11, "R9", "restart addr", maddr, 16'h4C11);
        @(negedge clk);
        check(mrd == 1'b0, "R9", "restart single", {15'd0, mrd}, 16'd0);
        rd_n = 1'b1;

        // R9: non-page mode, dedicated pins move during a read, no restart
        @(negedge clk);
        page_mode = 1'b0; fix = 8'h20; ad_in = 8'h30; ale = 1'b1;
        @(negedge clk);
        ale = 1'b0; ad_in = 8'h5F; rd_n = 1'b0;
        @(negedge clk);
        check(maddr == 16'h2030, "R9", "flat read addr", maddr, 16'h2030);
        fix = 8'h21;
        @(negedge clk);
        check(mrd == 1'b0, "R9", "flat no restart", {15'd0, mrd}, 16'd0);
        check(maddr == 16'h2030, "R9", "flat addr kept", maddr, 16'h2030);
        rd_n = 1'b1;
        #1;
        check(ad_oe == 1'b0, "R7", "release same cycle", {15'd0, ad_oe}, 16'd0);

        done = 1'b1;
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule